// File: doc/BRIEF.md
# Fast/Slow/Stop Clock Mode Controller

This block runs from a free-running oscillator clock and derives two clock phases from it: a CPU clock and a peripheral clock. A single select input picks one of two CPU rates. The fast rate divides the oscillator by 3. The slow rate divides it by 768. The peripheral clock always runs at half the fast CPU rate, whatever the select says. Both derived clocks are produced by registers, so they change only on oscillator edges and never glitch.

Two level-sensitive requests stop the derived clocks. A clock-stop request halts them while the oscillator keeps running. An oscillator-stop request also lowers an oscillator-run request output, which tells the external oscillator it may shut down. In both cases the clocks halt only at the end of a completed cycle, and they stay low while stopped.

To restart, both dividers are cleared together, so the CPU and peripheral clocks resume in a fixed phase relationship. After an oscillator stop, the restart waits for an external indication that the oscillator is stable again. A change of the select input takes effect only at the end of a 768-cycle frame, or while the clocks are stopped, so no clock phase is ever cut short.

Top module: `clk_mode_ctrl`

## Requirements
- R1: With the fast rate in effect (fast_sel = 1 latched), cpu_clk repeats a 3-cycle pattern: high for 1 oscillator cycle, then low for 2.
- R2: With the slow rate in effect (fast_sel = 0 latched), cpu_clk repeats a 768-cycle pattern: high for 256 oscillator cycles, then low for 512.
- R3: While the clocks run, a new fast_sel value is adopted only at the last cycle of a 768-cycle frame. While the clocks are stopped, fast_sel is followed continuously. A high or low phase is therefore never shorter than the fast-mode phase.
- R4: In either rate, per_clk repeats a 6-cycle pattern: high for 3 cycles, then low for 3.
- R5: When stop_clk_req = 1, the clocks halt at the end of the current cycle, and both cpu_clk and per_clk then stay low. In fast mode the cycle ends at the close of a 6-cycle peripheral period; in slow mode it ends at the close of a 768-cycle frame. osc_run_req stays 1 throughout.
- R6: When stop_osc_req = 1, the clocks halt at the same point as in R5, and osc_run_req then drops to 0. stop_osc_req takes priority over stop_clk_req.
- R7: Once both requests are 0, a clock stop ends on the next cycle. On the first output cycle after the restart, cpu_clk and per_clk both go high together.
- R8: After an oscillator stop, osc_run_req returns to 1 one cycle after stop_osc_req falls, and the clocks stay low until osc_ready = 1. When osc_ready = 1, the clocks restart as in R7. If stop_clk_req = 1 at that moment, the block enters a clock stop instead.
- R9: rst_n is a synchronous, active-low reset. While it is low, cpu_clk = 0, per_clk = 0 and osc_run_req = 1, and the fast rate is selected. On the first cycle after release, cpu_clk and per_clk are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_sel | input | 1 | 1 selects the divide-by-3 CPU rate, 0 selects divide-by-768 |
| stop_clk_req | input | 1 | Level request to halt the derived clocks while the oscillator keeps running |
| stop_osc_req | input | 1 | Level request to halt the derived clocks and release the oscillator |
| osc_ready | input | 1 | Oscillator is stable again after a stop |
| cpu_clk | output | 1 | Registered CPU clock phase |
| per_clk | output | 1 | Registered peripheral clock phase, 50% duty at half the fast CPU rate |
| osc_run_req | output | 1 | 1 while the oscillator is required to run |

## Verification
The two functions that can land on the same oscillator edge are the rate change and the stop. Both are decided at the last cycle of a slow frame. The bench provokes the clash by raising stop_clk_req and flipping fast_sel together in the middle of a slow frame. The clocks must keep their slow pattern until the frame closes. They must then stop there, and resume at the new fast rate with a single-cycle high phase. A behavioural model in the bench tracks the frame position as one integer and judges every output on every cycle. Directed measurements of phase widths back up that model at the edges of each mode.

// File: rtl/clk_mode_pkg.sv
// Package: shared types for the clock mode controller.
// Holds the sequencer state encoding and the lane indices of the output
// gating stage. Assumes nothing beyond a single oscillator clock domain.
package clk_mode_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_CLK_OFF  = 2'd1,
        ST_OSC_OFF  = 2'd2,
        ST_OSC_WAIT = 2'd3
    } cm_state_e;

    localparam int LANE_CPU = 0;
    localparam int LANE_PER = 1;
    localparam int N_LANES  = 2;

endpackage

// File: rtl/clk_mode_div.sv
// Module: clk_mode_div
// Frame counter for the derived clocks. A sub-counter walks one peripheral
// period (2*FAST_DIV cycles) and a block counter counts those periods up
// to one slow frame (SLOW_DIV cycles). Phase flags for the fast CPU clock,
// slow CPU clock and peripheral clock are decoded from the counter pair.
// Assumes SLOW_DIV is a multiple of 2*FAST_DIV. Both counters hold zero
// whenever run is low, so every restart begins at frame position 0.
module clk_mode_div #(
    parameter int FAST_DIV = 3,
    parameter int SLOW_DIV = 768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fast_ph,
    output logic slow_ph,
    output logic per_ph,
    output logic pair_end,
    output logic frame_end
);

    localparam int PER_DIV   = 2 * FAST_DIV;
    localparam int BLOCKS    = SLOW_DIV / PER_DIV;
    localparam int SUB_W     = $clog2(PER_DIV);
    localparam int BLK_W     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam int FAST_HIGH = (FAST_DIV / 3 > 0) ? FAST_DIV / 3 : 1;
    localparam int SLOW_HIGH = SLOW_DIV / 3;

    logic [SUB_W-1:0] sub_q;
    logic [BLK_W-1:0] blk_q;
    logic             blk_last;
    int               pos_i;
    int               sub_i;

    assign pair_end  = (sub_q == SUB_W'(PER_DIV - 1));
    assign blk_last  = (blk_q == BLK_W'(BLOCKS - 1));
    assign frame_end = pair_end && blk_last;

    // Advance the period/frame counters while running, clear them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q <= '0;
            blk_q <= '0;
        end else if (pair_end) begin
            sub_q <= '0;
            blk_q <= blk_last ? '0 : blk_q + BLK_W'(1);
        end else begin
            sub_q <= sub_q + SUB_W'(1);
        end
    end

    // Decode the phase flags from the current frame position.
    always_comb begin
        sub_i   = int'(sub_q);
        pos_i   = int'(blk_q) * PER_DIV + sub_i;
        slow_ph = (pos_i < SLOW_HIGH);
        fast_ph = (sub_i < FAST_HIGH) ||
                  ((sub_i >= FAST_DIV) && (sub_i < FAST_DIV + FAST_HIGH));
        per_ph  = (sub_i < FAST_DIV);
    end

endmodule

// File: rtl/clk_mode_seq.sv
// Module: clk_mode_seq
// Stop/restart sequencer and rate latch. It decides when the derived
// clocks run, when the oscillator may stop, and which CPU rate is in
// force. A stop is taken only at the end of a completed cycle: the end
// of a peripheral period in fast mode, the end of a frame in slow mode.
// Assumes the request inputs are already synchronous to clk.
module clk_mode_seq
    import clk_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    input  logic stop_clk_req,
    input  logic stop_osc_req,
    input  logic osc_ready,
    input  logic pair_end,
    input  logic frame_end,
    output logic run,
    output logic mode_fast,
    output logic osc_run
);

    cm_state_e state_q, state_d;
    logic      at_end;
    logic      any_stop;

    assign run      = (state_q == ST_RUN);
    assign osc_run  = (state_q != ST_OSC_OFF);
    assign at_end   = mode_fast ? pair_end : frame_end;
    assign any_stop = stop_clk_req || stop_osc_req;

    // Next-state choice for stop, oscillator wait and restart.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_stop && at_end)
                    state_d = stop_osc_req ? ST_OSC_OFF : ST_CLK_OFF;
            end
            ST_CLK_OFF: begin
                if (stop_osc_req)
                    state_d = ST_OSC_OFF;
                else if (!stop_clk_req)
                    state_d = ST_RUN;
            end
            ST_OSC_OFF: begin
                if (!stop_osc_req)
                    state_d = ST_OSC_WAIT;
            end
            ST_OSC_WAIT: begin
                if (stop_osc_req)
                    state_d = ST_OSC_OFF;
                else if (osc_ready)
                    state_d = stop_clk_req ? ST_CLK_OFF : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // Rate latch: follows the select while stopped, else only at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_fast <= 1'b1;
        else if (!run || frame_end)
            mode_fast <= fast_sel;
    end

endmodule

// File: rtl/clk_mode_gate.sv
// Module: clk_mode_gate
// Output register stage. Each lane registers its decoded phase ANDed
// with the run flag, so every derived clock leaves the block straight
// from a flop and cannot glitch. Assumes phases are decoded from
// registered state in the same clock domain.
module clk_mode_gate #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LANES-1:0] phase_in,
    output logic [LANES-1:0] clk_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Register one gated clock lane, low in reset and when not running.
        always_ff @(posedge clk) begin
            if (!rst_n)
                clk_out[g] <= 1'b0;
            else
                clk_out[g] <= run && phase_in[g];
        end
    end

endmodule

// File: rtl/clk_mode_ctrl.sv
// Module: clk_mode_ctrl (top)
// Fast/slow/stop clock mode controller. It derives a CPU clock (divide by
// FAST_DIV or SLOW_DIV) and a peripheral clock (divide by 2*FAST_DIV)
// from osc_clk. It stops them cleanly on request, optionally releasing
// the oscillator, and restarts them phase aligned. Assumes osc_clk keeps
// toggling and all inputs are synchronous to it.
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int FAST_DIV = 3,
    parameter int SLOW_DIV = 768
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic fast_sel,
    input  logic stop_clk_req,
    input  logic stop_osc_req,
    input  logic osc_ready,
    output logic cpu_clk,
    output logic per_clk,
    output logic osc_run_req
);

    logic               run;
    logic               mode_fast;
    logic               fast_ph, slow_ph, per_ph;
    logic               pair_end, frame_end;
    logic [N_LANES-1:0] phases;
    logic [N_LANES-1:0] gated;

    clk_mode_div #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_div (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .run       (run),
        .fast_ph   (fast_ph),
        .slow_ph   (slow_ph),
        .per_ph    (per_ph),
        .pair_end  (pair_end),
        .frame_end (frame_end)
    );

    clk_mode_seq u_seq (
        .clk          (osc_clk),
        .rst_n        (rst_n),
        .fast_sel     (fast_sel),
        .stop_clk_req (stop_clk_req),
        .stop_osc_req (stop_osc_req),
        .osc_ready    (osc_ready),
        .pair_end     (pair_end),
        .frame_end    (frame_end),
        .run          (run),
        .mode_fast    (mode_fast),
        .osc_run      (osc_run_req)
    );

    // Pick the CPU phase for the latched rate; peripheral phase is fixed.
    always_comb begin
        phases           = '0;
        phases[LANE_CPU] = mode_fast ? fast_ph : slow_ph;
        phases[LANE_PER] = per_ph;
    end

    clk_mode_gate #(
        .LANES (N_LANES)
    ) u_gate (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .run      (run),
        .phase_in (phases),
        .clk_out  (gated)
    );

    assign cpu_clk = gated[LANE_CPU];
    assign per_clk = gated[LANE_PER];

endmodule

// File: rtl/clk_mode_ctrl_chk.sv
// Module: clk_mode_ctrl_chk
// Port-level protocol checks for clk_mode_ctrl, attached with bind.
// Assumes rst_n is synchronous to osc_clk.
module clk_mode_ctrl_chk (
    input logic osc_clk,
    input logic rst_n,
    input logic cpu_clk,
    input logic per_clk,
    input logic osc_run_req
);

    // R1: a CPU low phase lasts at least two cycles in every mode.
    assert_cpu_low_min_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(cpu_clk) |=> !cpu_clk);

    // R4: a peripheral high phase is never a single cycle.
    assert_per_high_min_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(per_clk) |=> per_clk);

    // R4: a peripheral low phase is never a single cycle.
    assert_per_low_min_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(per_clk) |=> !per_clk);

    // R6: with the oscillator released, both derived clocks are low.
    assert_osc_off_quiet_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !osc_run_req |-> (!cpu_clk && !per_clk));

    // R8: no clock pulse in the cycle after the oscillator is requested again.
    assert_osc_wait_quiet_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(osc_run_req) |=> (!cpu_clk && !per_clk));

endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
    .osc_clk     (osc_clk),
    .rst_n       (rst_n),
    .cpu_clk     (cpu_clk),
    .per_clk     (per_clk),
    .osc_run_req (osc_run_req)
);

// File: tb/clk_mode_ctrl_test.sv
`timescale 1ns/1ps
module clk_mode_ctrl_test;

    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_sel = 1'b1;
    logic stop_clk_req = 1'b0;
    logic stop_osc_req = 1'b0;
    logic osc_ready = 1'b1;
    logic cpu_clk, per_clk, osc_run_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 osc_clk = ~osc_clk;

    clk_mode_ctrl uut (
        .osc_clk      (osc_clk),
        .rst_n        (rst_n),
        .fast_sel     (fast_sel),
        .stop_clk_req (stop_clk_req),
        .stop_osc_req (stop_osc_req),
        .osc_ready    (osc_ready),
        .cpu_clk      (cpu_clk),
        .per_clk      (per_clk),
        .osc_run_req  (osc_run_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: state 0 run, 1 clock off, 2 osc off, 3 osc wait.
    int m_state = 0, m_pos = 0;
    bit m_fast = 1, m_seen = 0;
    bit e_cpu = 0, e_per = 0, e_osc = 1;

    always @(posedge osc_clk) begin
        bit run, at_end;
        int nxt;
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_pos = 0; m_fast = 1;
            e_cpu = 0; e_per = 0; e_osc = 1;
        end else begin
            run    = (m_state == 0);
            e_cpu  = run && (m_fast ? (m_pos % 3 == 0) : (m_pos < 256));
            e_per  = run && (m_pos % 6 < 3);
            at_end = m_fast ? (m_pos % 6 == 5) : (m_pos == 767);
            nxt = m_state;
            case (m_state)
                0: if ((stop_clk_req || stop_osc_req) && at_end) nxt = stop_osc_req ? 2 : 1;
                1: if (stop_osc_req) nxt = 2; else if (!stop_clk_req) nxt = 0;
                2: if (!stop_osc_req) nxt = 3;
                default: if (stop_osc_req) nxt = 2;
                         else if (osc_ready) nxt = stop_clk_req ? 1 : 0;
            endcase
            if (!run || m_pos == 767) m_fast = fast_sel;
            m_pos = (run && nxt == 0) ? (m_pos + 1) % 768 : 0;
            m_state = nxt;
            e_osc = (m_state != 2);
        end
        m_seen = 1;
    end

    // Compare the outputs with the model on every cycle.
    always @(negedge osc_clk) begin
        if (m_seen && !done) begin
            chk(cpu_clk == e_cpu, m_fast ? "R1 cpu_clk vs model" : "R2 cpu_clk vs model",
                cpu_clk, e_cpu);
            chk(per_clk == e_per, "R4 per_clk vs model", per_clk, e_per);
            chk(osc_run_req == e_osc, "R6 osc_run_req vs model", osc_run_req, e_osc);
        end
    end

    // Watchdog.
    always @(posedge osc_clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_cpu_high(input int lim);
        int n = 0;
        while (!cpu_clk && n < lim) begin @(negedge osc_clk); n++; end
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (cpu_clk == lvl && n < 2000) begin n++; @(negedge osc_clk); end
    endtask

    task automatic count_high(input int cyc, output int nc, output int np);
        nc = 0; np = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge osc_clk);
            nc += int'(cpu_clk);
            np += int'(per_clk);
        end
    endtask

    initial begin
        int nc, np, len;
        repeat (4) @(negedge osc_clk);
        chk(!cpu_clk && !per_clk, "R9 clocks low in reset", {cpu_clk, per_clk}, 0);
        chk(osc_run_req, "R9 osc_run_req high in reset", osc_run_req, 1);
        rst_n = 1'b1;
        @(negedge osc_clk);
        chk(cpu_clk && per_clk, "R9 both clocks high after release", {cpu_clk, per_clk}, 3);

        // R1 and R4 in fast mode
        count_high(30, nc, np);
        chk(nc == 10, "R1 fast cpu highs in 30 cycles", nc, 10);
        chk(np == 15, "R4 fast per highs in 30 cycles", np, 15);

        // R2: switch to slow, observe full frame
        fast_sel = 1'b0;
        len = 1;
        while (len <= 1) begin
            wait_cpu_high(2000);
            run_len(1'b1, len);
        end
        chk(len == 256, "R2 slow cpu high width", len, 256);
        run_len(1'b0, len);
        chk(len == 512, "R2 slow cpu low width", len, 512);

        // R3: select flipped at start of a slow high phase is ignored this frame
        fast_sel = 1'b1;
        run_len(1'b1, len);
        chk(len == 256, "R3 high width unchanged mid-frame", len, 256);
        run_len(1'b0, len);
        chk(len == 512, "R3 low width unchanged mid-frame", len, 512);
        run_len(1'b1, len);
        chk(len == 1, "R3 fast high after frame end", len, 1);

        // R5: clock stop in fast mode
        stop_clk_req = 1'b1;
        repeat (8) @(negedge osc_clk);
        count_high(20, nc, np);
        chk(nc == 0 && np == 0, "R5 clocks held low in clock stop", nc + np, 0);
        chk(osc_run_req, "R5 osc_run_req stays high", osc_run_req, 1);

        // R7: restart aligned
        stop_clk_req = 1'b0;
        wait_cpu_high(20);
        chk(cpu_clk && per_clk, "R7 cpu and per rise together", {cpu_clk, per_clk}, 3);

        // R3/R5 overlap: slow frame, stop and rate flip raised together mid-frame
        fast_sel = 1'b0;
        repeat (800) @(negedge osc_clk);
        wait_cpu_high(2000);
        repeat (10) @(negedge osc_clk);
        stop_clk_req = 1'b1; fast_sel = 1'b1;
        chk(cpu_clk, "R5 slow high phase not cut by stop", cpu_clk, 1);
        repeat (800) @(negedge osc_clk);
        chk(!cpu_clk && !per_clk, "R5 stopped at slow frame end", {cpu_clk, per_clk}, 0);
        stop_clk_req = 1'b0;
        wait_cpu_high(20);
        chk(per_clk, "R7 per high on restart", per_clk, 1);
        run_len(1'b1, len);
        chk(len == 1, "R3 new fast rate after stop", len, 1);

        // R6/R8: oscillator stop and wait for ready
        stop_osc_req = 1'b1; osc_ready = 1'b0;
        repeat (10) @(negedge osc_clk);
        chk(!osc_run_req, "R6 osc_run_req low", osc_run_req, 0);
        chk(!cpu_clk && !per_clk, "R6 clocks low", {cpu_clk, per_clk}, 0);
        stop_osc_req = 1'b0;
        repeat (2) @(negedge osc_clk);
        chk(osc_run_req, "R8 osc_run_req back high", osc_run_req, 1);
        count_high(10, nc, np);
        chk(nc + np == 0, "R8 clocks wait for osc_ready", nc + np, 0);
        osc_ready = 1'b1;
        wait_cpu_high(20);
        chk(cpu_clk && per_clk, "R8 aligned restart after ready", {cpu_clk, per_clk}, 3);

        // R8: clock stop still asserted when oscillator becomes ready
        stop_osc_req = 1'b1; stop_clk_req = 1'b1; osc_ready = 1'b0;
        repeat (10) @(negedge osc_clk);
        stop_osc_req = 1'b0;
        repeat (3) @(negedge osc_clk);
        osc_ready = 1'b1;
        count_high(20, nc, np);
        chk(nc + np == 0, "R8 ready with clock stop held stays stopped", nc + np, 0);
        chk(osc_run_req, "R8 oscillator kept running", osc_run_req, 1);
        stop_clk_req = 1'b0;
        wait_cpu_high(20);
        chk(cpu_clk && per_clk, "R7 restart after held clock stop", {cpu_clk, per_clk}, 3);
        repeat (20) @(negedge osc_clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule